// File: doc/BRIEF.md
# Configurable approximate ternary digit multiplier

This block multiplies two ternary digits and returns the result as a low product digit and a carry digit, each digit carried as a 2-bit binary code. A mode input chooses between exact multiplication and five approximate behaviours that trade accuracy for a cheaper datapath downstream. Every approximation touches only one input pair: both operands equal to 2. All other pairs give the exact result in every mode.

One approximate mode is stateful. For the 2×2 pair it returns the product digit that the block last produced for an ordinary (not 2×2) input, so a register holds that digit across cycles. Results are registered with one cycle of latency and qualified by a valid flag. An operand carrying the unused code raises an error flag and the results are zeroed.

Top module: `tmul_approx_top`

## Requirements
- R1: Digits are coded 2'b00=0, 2'b01=1, 2'b10=2. For any legal pair other than 2×2, in every mode, the product digit is (a·b) mod 3 and the carry is 0 (0 with anything gives 0, 1×1 gives 1, 1×2 and 2×1 give 2).
- R2: Mode code 0 (exact) gives product 1 and carry 1 for 2×2; mode codes 6 and 7 behave exactly like code 0.
- R3: Mode code 1 gives product 0 and carry 0 for 2×2, so its carry is 0 for every input.
- R4: Mode code 2 gives product 2 and carry 0 for 2×2, so its carry is 0 for every input.
- R5: Mode code 3 gives product 0 and carry 1 for 2×2.
- R6: Mode code 4 gives product 2 and carry 1 for 2×2.
- R7: Mode code 5 gives carry 1 and, as product, the held digit for 2×2. The held digit takes the produced product digit on every clock edge with in_valid high and operands not both 2; it is unchanged by 2×2 inputs in any mode and is 0 after reset.
- R8: If either operand is 2'b11, the error output is 1 and product and carry are 0 for that result; the held digit becomes 0.
- R9: Results appear one clock after the inputs are accepted; out_valid is in_valid delayed by one clock. While in_valid is low, product, carry and error keep their previous values.
- R10: A synchronous active-low reset clears out_valid, product, carry, error and the held digit to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 3 | Behaviour select, 0 exact, 1 to 5 approximate, 6 and 7 exact |
| trit_a | input | 2 | First operand digit |
| trit_b | input | 2 | Second operand digit |
| out_valid | output | 1 | Registered results are valid |
| prod | output | 2 | Product digit |
| carry | output | 2 | Carry digit |
| code_err | output | 1 | An operand carried the illegal code |

## Verification
The held digit is written and read by neighbouring operations, and the two meet when a 2×2 pair in mode 5 follows immediately after an ordinary pair, so the digit written at one edge is the one returned at the next. The bench runs such back-to-back pairs, inserts 2×2 pairs in other modes between them to show they leave the digit alone, and places an illegal code right before a mode 5 2×2 pair so the zeroing write and the reuse collide. Each result is judged against a bench model that keeps its own copy of the held digit.

// File: rtl/tmul_pkg.sv
package tmul_pkg;

    localparam int TRIT_W = 2;
    localparam int MODE_W = 3;

    typedef logic [TRIT_W-1:0] trit_t;
    typedef logic [MODE_W-1:0] mode_t;

    localparam trit_t TRIT_ZERO = 2'd0;
    localparam trit_t TRIT_ONE  = 2'd1;
    localparam trit_t TRIT_TWO  = 2'd2;
    localparam trit_t TRIT_BAD  = 2'd3;

    localparam mode_t MODE_EXACT       = 3'd0;
    localparam mode_t MODE_ZERO_NOCY   = 3'd1;
    localparam mode_t MODE_TWO_NOCY    = 3'd2;
    localparam mode_t MODE_ZERO_CY     = 3'd3;
    localparam mode_t MODE_TWO_CY      = 3'd4;
    localparam mode_t MODE_REUSE       = 3'd5;

    typedef struct packed {
        logic  vld;
        logic  err;
        trit_t prod;
        trit_t carry;
        trit_t held;
    } tmul_state_t;

endpackage

// File: rtl/tmul_trit_check.sv
module tmul_trit_check
    import tmul_pkg::*;
(
    input  trit_t op_a_i,
    input  trit_t op_b_i,
    output logic  bad_o,
    output logic  both_two_o
);

    logic [1:0] is_bad;
    logic [1:0] is_two;
    trit_t      ops [2];

    assign ops[0] = op_a_i;
    assign ops[1] = op_b_i;

    for (genvar g = 0; g < 2; g++) begin : g_op
        assign is_bad[g] = (ops[g] == TRIT_BAD);
        assign is_two[g] = (ops[g] == TRIT_TWO);
    end

    always_comb begin
        bad_o      = |is_bad;
        both_two_o = &is_two;
    end

endmodule

// File: rtl/tmul_exact_core.sv
module tmul_exact_core
    import tmul_pkg::*;
(
    input  trit_t op_a_i,
    input  trit_t op_b_i,
    output trit_t prod_o,
    output trit_t carry_o
);

    always_comb begin
        prod_o  = TRIT_ZERO;
        carry_o = TRIT_ZERO;
        unique case ({op_a_i, op_b_i})
            {TRIT_ONE, TRIT_ONE}: prod_o = TRIT_ONE;
            {TRIT_ONE, TRIT_TWO},
            {TRIT_TWO, TRIT_ONE}: prod_o = TRIT_TWO;
            {TRIT_TWO, TRIT_TWO}: begin
                prod_o  = TRIT_ONE;
                carry_o = TRIT_ONE;
            end
            default: begin
                prod_o  = TRIT_ZERO;
                carry_o = TRIT_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/tmul_mode_fix.sv
module tmul_mode_fix
    import tmul_pkg::*;
(
    input  mode_t mode_i,
    input  logic  both_two_i,
    input  trit_t exact_prod_i,
    input  trit_t exact_carry_i,
    input  trit_t held_i,
    output trit_t prod_o,
    output trit_t carry_o
);

    always_comb begin
        prod_o  = exact_prod_i;
        carry_o = exact_carry_i;
        if (both_two_i) begin
            case (mode_i)
                MODE_ZERO_NOCY: begin
                    prod_o  = TRIT_ZERO;
                    carry_o = TRIT_ZERO;
                end
                MODE_TWO_NOCY: begin
                    prod_o  = TRIT_TWO;
                    carry_o = TRIT_ZERO;
                end
                MODE_ZERO_CY: begin
                    prod_o  = TRIT_ZERO;
                    carry_o = TRIT_ONE;
                end
                MODE_TWO_CY: begin
                    prod_o  = TRIT_TWO;
                    carry_o = TRIT_ONE;
                end
                MODE_REUSE: begin
                    prod_o  = held_i;
                    carry_o = TRIT_ONE;
                end
                default: begin
                    prod_o  = exact_prod_i;
                    carry_o = exact_carry_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/tmul_approx_top.sv
module tmul_approx_top
    import tmul_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [2:0] mode,
    input  logic [1:0] trit_a,
    input  logic [1:0] trit_b,
    output logic       out_valid,
    output logic [1:0] prod,
    output logic [1:0] carry,
    output logic       code_err
);

    tmul_state_t st_d, st_q;

    logic  op_bad;
    logic  op_both_two;
    trit_t ex_prod, ex_carry;
    trit_t fix_prod, fix_carry;

    tmul_trit_check u_check (
        .op_a_i     (trit_a),
        .op_b_i     (trit_b),
        .bad_o      (op_bad),
        .both_two_o (op_both_two)
    );

    tmul_exact_core u_exact (
        .op_a_i  (trit_a),
        .op_b_i  (trit_b),
        .prod_o  (ex_prod),
        .carry_o (ex_carry)
    );

    tmul_mode_fix u_fix (
        .mode_i        (mode),
        .both_two_i    (op_both_two),
        .exact_prod_i  (ex_prod),
        .exact_carry_i (ex_carry),
        .held_i        (st_q.held),
        .prod_o        (fix_prod),
        .carry_o       (fix_carry)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (op_bad) begin
                st_d.err   = 1'b1;
                st_d.prod  = TRIT_ZERO;
                st_d.carry = TRIT_ZERO;
                st_d.held  = TRIT_ZERO;
            end else begin
                st_d.err   = 1'b0;
                st_d.prod  = fix_prod;
                st_d.carry = fix_carry;
                if (!op_both_two) begin
                    st_d.held = fix_prod;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign prod      = st_q.prod;
    assign carry     = st_q.carry;
    assign code_err  = st_q.err;

    a_r1_no_carry_ordinary: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && !op_bad && !op_both_two) |=> (carry == TRIT_ZERO && prod != TRIT_BAD));

    a_r3_r4_carry_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && (mode == MODE_ZERO_NOCY || mode == MODE_TWO_NOCY)) |=> (carry == TRIT_ZERO));

    a_r7_reuse_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && !op_bad && op_both_two && mode == MODE_REUSE)
        |=> (prod == $past(st_q.held) && carry == TRIT_ONE));

    a_r7_held_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && op_both_two) |=> $stable(st_q.held));

    a_r8_err_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> (prod == TRIT_ZERO && carry == TRIT_ZERO));

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid) |=> out_valid);

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid) |=> (!out_valid && $stable(prod) && $stable(carry) && $stable(code_err)));

endmodule

// File: tb/test_tmul_approx_top.sv
module test_tmul_approx_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [1:0] trit_a = 2'd0;
    logic [1:0] trit_b = 2'd0;
    logic       out_valid;
    logic [1:0] prod;
    logic [1:0] carry;
    logic       code_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmul_approx_top i_tmul_approx_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mode      (mode),
        .trit_a    (trit_a),
        .trit_b    (trit_b),
        .out_valid (out_valid),
        .prod      (prod),
        .carry     (carry),
        .code_err  (code_err)
    );

    typedef struct {
        logic       vld;
        logic       err;
        logic [1:0] prod;
        logic [1:0] carry;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [1:0] m_held  = 2'd0;
    logic [1:0] m_prod  = 2'd0;
    logic [1:0] m_carry = 2'd0;
    logic       m_err   = 1'b0;

    function automatic string tag_of(input logic [2:0] m, input logic [1:0] a, input logic [1:0] b);
        if (a == 2'd3 || b == 2'd3) return "R8";
        if (!(a == 2'd2 && b == 2'd2)) return "R1";
        case (m)
            3'd1:    return "R3";
            3'd2:    return "R4";
            3'd3:    return "R5";
            3'd4:    return "R6";
            3'd5:    return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic step(input logic v, input logic [2:0] m, input logic [1:0] a,
                        input logic [1:0] b, input string tag);
        exp_t e;
        int   pr;
        @(negedge clk);
        in_valid = v;
        mode     = m;
        trit_a   = a;
        trit_b   = b;
        if (v) begin
            if (a == 2'd3 || b == 2'd3) begin
                m_err = 1'b1; m_prod = 2'd0; m_carry = 2'd0; m_held = 2'd0;
            end else begin
                m_err = 1'b0;
                pr    = int'(a) * int'(b);
                if (a == 2'd2 && b == 2'd2) begin
                    case (m)
                        3'd1:    begin m_prod = 2'd0;   m_carry = 2'd0; end
                        3'd2:    begin m_prod = 2'd2;   m_carry = 2'd0; end
                        3'd3:    begin m_prod = 2'd0;   m_carry = 2'd1; end
                        3'd4:    begin m_prod = 2'd2;   m_carry = 2'd1; end
                        3'd5:    begin m_prod = m_held; m_carry = 2'd1; end
                        default: begin m_prod = 2'd1;   m_carry = 2'd1; end
                    endcase
                end else begin
                    m_prod  = 2'(pr % 3);
                    m_carry = 2'(pr / 3);
                    m_held  = m_prod;
                end
            end
        end
        e.vld = v; e.err = m_err; e.prod = m_prod; e.carry = m_carry; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || prod !== 2'd0 || carry !== 2'd0 || code_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset state: vld=%b prod=%0d carry=%0d err=%b expected 0 0 0 0",
                     out_valid, prod, carry, code_err);
        end
        rst_n   = 1'b1;
        m_held  = 2'd0; m_prod = 2'd0; m_carry = 2'd0; m_err = 1'b0;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_vec++;
                if (out_valid !== e.vld || prod !== e.prod || carry !== e.carry || code_err !== e.err) begin
                    n_fail++;
                    $display("FAIL %s: got vld=%b prod=%0d carry=%0d err=%b, expected vld=%b prod=%0d carry=%0d err=%b",
                             e.tag, out_valid, prod, carry, code_err, e.vld, e.prod, e.carry, e.err);
                end
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : driver
        do_reset();

        // R1..R7: every mode against every legal operand pair
        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < 3; a++) begin
                for (int b = 0; b < 3; b++) begin
                    step(1'b1, 3'(m), 2'(a), 2'(b), tag_of(3'(m), 2'(a), 2'(b)));
                end
            end
        end

        // R7: reuse right after an ordinary result, held digit 1 -> exact
        step(1'b1, 3'd5, 2'd1, 2'd1, "R1");
        step(1'b1, 3'd5, 2'd2, 2'd2, "R7");
        // R7: held digit 2, then 2x2 in other modes must not disturb it
        step(1'b1, 3'd2, 2'd2, 2'd1, "R1");
        step(1'b1, 3'd0, 2'd2, 2'd2, "R2");
        step(1'b1, 3'd3, 2'd2, 2'd2, "R5");
        step(1'b1, 3'd5, 2'd2, 2'd2, "R7");
        step(1'b1, 3'd5, 2'd2, 2'd2, "R7");

        // R8: illegal code on each side, then reuse sees cleared digit
        step(1'b1, 3'd0, 2'd3, 2'd2, "R8");
        step(1'b1, 3'd5, 2'd2, 2'd2, "R7");
        step(1'b1, 3'd4, 2'd1, 2'd2, "R1");
        step(1'b1, 3'd4, 2'd2, 2'd3, "R8");
        step(1'b1, 3'd1, 2'd3, 2'd3, "R8");
        step(1'b1, 3'd6, 2'd1, 2'd1, "R1");

        // R9: idle cycles with changing inputs leave results in place
        step(1'b1, 3'd7, 2'd2, 2'd2, "R2");
        step(1'b0, 3'd5, 2'd3, 2'd3, "R9");
        step(1'b0, 3'd1, 2'd1, 2'd2, "R9");
        step(1'b1, 3'd0, 2'd0, 2'd2, "R9");
        step(1'b0, 3'd0, 2'd2, 2'd2, "R9");

        // R10: reset clears the held digit
        step(1'b1, 3'd0, 2'd1, 2'd2, "R1");
        step(1'b0, 3'd0, 2'd0, 2'd0, "R9");
        repeat (2) @(posedge clk);
        do_reset();
        step(1'b1, 3'd5, 2'd2, 2'd2, "R10");
        step(1'b0, 3'd0, 2'd0, 2'd0, "R9");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule